// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends one command byte from a host to a PS/2 keyboard or mouse. The two bus wires are open-collector, so the block does not drive them directly. For each wire it gives a "pull low" enable and reads back the resolved level of that wire. A single-cycle start strobe captures the byte. The block then seizes the bus in two phases:

1. It holds the clock wire low long enough to silence the device.
2. It lowers the data wire and lets the clock wire go. This is the request-to-send.

From then on the device drives every clock pulse. The block only moves the data wire while the device holds the clock low.

The byte goes out in an eleven-slot frame:

- a start bit of 0 (the request-to-send itself)
- eight data bits, least significant first
- an odd parity bit
- a stop bit of 1

On the eleventh falling clock edge the block checks that the device is holding data low as its acknowledge. It then reports success or a missing acknowledge with a one-cycle pulse. A device that never starts clocking is reported as a timeout. A host-side abort request drops the frame and re-inhibits the bus.

All time limits are counted on the system clock from a cycles-per-microsecond parameter. Both wire inputs pass through two-flop synchronizers. Device clock edges are detected on the synchronized level, so a falling edge at the input takes effect on the third system clock edge after the input first reads low.

Top module: `ps2_cmd_tx`

## Requirements
- R1: While reset is asserted and after it is released, both pull-low enables, `busy_o`, `done_o`, `nack_o` and `timeout_o` are 0.
- R2: A `start_i` pulse while idle captures `cmd_i` and drives `clk_drive_low_o` high for CYC_PER_US*INHIBIT_US cycles with data released. The clock stays low for one further cycle in the seize step, so the clock enable is high for that count plus one cycles in total.
- R3: After the inhibit interval, `dat_drive_low_o` rises one cycle before `clk_drive_low_o` falls, and data stays pulled low when the clock is released (request-to-send).
- R4: From the request-to-send until the transfer ends, the block never pulls the clock wire low unless `abort_i` is asserted.
- R5: On device clock falls 1 to 10, the data wire carries, in this order, `cmd_i` bits 0 to 7, odd parity (1 when the byte has an even number of ones), and a stop bit of 1 (released). Each change happens on the third system clock edge after `ps2_clk_i` first reads low, so data only moves while the device clock is low.
- R6: If `ps2_dat_i` is low when the 11th device clock fall takes effect, `done_o` pulses for one cycle and the block returns to idle with both wires released.
- R7: If `ps2_dat_i` is high at that 11th fall, `nack_o` pulses for one cycle instead of `done_o`.
- R8: If no device clock fall takes effect within CYC_PER_US*TIMEOUT_US cycles after the clock is released, `timeout_o` pulses for one cycle and both wires are released.
- R9: `abort_i` during inhibit, seize or transfer releases data, pulls the clock low for CYC_PER_US*INHIBIT_US cycles, and then returns to idle without any done or error pulse.
- R10: `start_i` while busy and `abort_i` while idle have no effect: the frame in progress keeps its byte, and an idle block stays idle.
- R11: At most one of `done_o`, `nack_o` and `timeout_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to send `cmd_i` |
| cmd_i | input | 8 | Command byte, captured on `start_i` |
| abort_i | input | 1 | Drop the current frame and re-inhibit the bus |
| ps2_clk_i | input | 1 | Resolved level of the clock wire |
| ps2_dat_i | input | 1 | Resolved level of the data wire |
| clk_drive_low_o | output | 1 | Pull the clock wire low when 1 |
| dat_drive_low_o | output | 1 | Pull the data wire low when 1 |
| busy_o | output | 1 | A frame, inhibit or abort is in progress |
| done_o | output | 1 | One-cycle pulse: byte acknowledged |
| nack_o | output | 1 | One-cycle pulse: no acknowledge seen |
| timeout_o | output | 1 | One-cycle pulse: device never started clocking |

## Verification
The assertions assume that the device holds each clock level for many more system cycles than the synchronizer delay. The data-change property looks exactly three samples back on `ps2_clk_i` and relies on that. The bench's device model keeps every clock phase at twenty system cycles. It moves its own data (the acknowledge) only while its clock is high and well away from any edge. `start_i` and `abort_i` are driven as single-cycle pulses on the falling system clock edge. Abort is only raised while the device clock is idle high, so no abort races a device edge.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE    = 3'd0,
    TX_INHIBIT = 3'd1,
    TX_SEIZE   = 3'd2,
    TX_XFER    = 3'd3,
    TX_ABORT   = 3'd4
  } tx_state_e;

  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 2;  // data, parity, stop

  function automatic logic odd_parity(input logic [BYTE_W-1:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);

  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
    else        pipe <= {pipe[STAGES-1:0], line_i};
  end

  assign level_o = pipe[STAGES-1];
  assign fall_o  = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/ps2_tx_timer.sv
module ps2_tx_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ps2_tx_frame.sv
module ps2_tx_frame
  import ps2tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              adv_i,
  output logic              bit_o,
  output logic              first_o,
  output logic              last_o
);

  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sreg_q, sreg_d;
  logic                  cur_q, cur_d;
  logic [CW-1:0]         cnt_q, cnt_d;

  always_comb begin
    sreg_d = sreg_q;
    cur_d  = cur_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      sreg_d = {1'b1, odd_parity(byte_i), byte_i};
      cur_d  = 1'b0;  // start bit
      cnt_d  = '0;
    end else if (adv_i) begin
      sreg_d = {1'b1, sreg_q[FRAME_BITS-1:1]};
      cur_d  = sreg_q[0];
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      cur_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      cur_q  <= cur_d;
      cnt_q  <= cnt_d;
    end
  end

  assign bit_o   = cur_q;
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CW'(FRAME_BITS));

endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
  import ps2tx_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int INHIBIT_US = 110,
  parameter int TIMEOUT_US = 15000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic              abort_i,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  output logic              clk_drive_low_o,
  output logic              dat_drive_low_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              nack_o,
  output logic              timeout_o
);

  localparam int INH_CYC = CYC_PER_US * INHIBIT_US;
  localparam int TMO_CYC = CYC_PER_US * TIMEOUT_US;
  localparam int MAX_CYC = (INH_CYC > TMO_CYC) ? INH_CYC : TMO_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // line synchronizers
  logic clk_lvl, clk_fall, dat_lvl, dat_fall;

  ps2_line_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_clk (
    .clk(clk), .rst_n(rst_int_n), .line_i(ps2_clk_i),
    .level_o(clk_lvl), .fall_o(clk_fall)
  );

  ps2_line_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_dat (
    .clk(clk), .rst_n(rst_int_n), .line_i(ps2_dat_i),
    .level_o(dat_lvl), .fall_o(dat_fall)
  );

  // timer and frame shifter
  logic          tmr_load, tmr_dec, tmr_zero;
  logic [TW-1:0] tmr_val;

  ps2_tx_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .dec_i(tmr_dec), .zero_o(tmr_zero)
  );

  logic frm_load, frm_adv, frm_bit, frm_first, frm_last;

  ps2_tx_frame u_frame (
    .clk(clk), .rst_n(rst_int_n), .load_i(frm_load), .byte_i(cmd_i),
    .adv_i(frm_adv), .bit_o(frm_bit), .first_o(frm_first), .last_o(frm_last)
  );

  // control
  tx_state_e state_q, state_d;
  logic      done_d, nack_d, tmo_d;
  logic      done_q, nack_q, tmo_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    tmr_val  = TW'(INH_CYC - 1);
    frm_load = 1'b0;
    frm_adv  = 1'b0;
    done_d   = 1'b0;
    nack_d   = 1'b0;
    tmo_d    = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (start_i) begin
          state_d  = TX_INHIBIT;
          tmr_load = 1'b1;
          frm_load = 1'b1;
        end
      end
      TX_INHIBIT: begin
        if (abort_i) begin
          state_d  = TX_ABORT;
          tmr_load = 1'b1;
        end else if (tmr_zero) begin
          state_d = TX_SEIZE;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      TX_SEIZE: begin
        if (abort_i) begin
          state_d  = TX_ABORT;
          tmr_load = 1'b1;
        end else begin
          state_d  = TX_XFER;
          tmr_load = 1'b1;
          tmr_val  = TW'(TMO_CYC - 1);
        end
      end
      TX_XFER: begin
        if (abort_i) begin
          state_d  = TX_ABORT;
          tmr_load = 1'b1;
        end else if (clk_fall) begin
          if (frm_last) begin
            state_d = TX_IDLE;
            done_d  = ~dat_lvl;
            nack_d  = dat_lvl;
          end else begin
            frm_adv = 1'b1;
          end
        end else if (frm_first) begin
          if (tmr_zero) begin
            state_d = TX_IDLE;
            tmo_d   = 1'b1;
          end else begin
            tmr_dec = 1'b1;
          end
        end
      end
      TX_ABORT: begin
        if (tmr_zero) state_d = TX_IDLE;
        else          tmr_dec = 1'b1;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= TX_IDLE;
      done_q  <= 1'b0;
      nack_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      nack_q  <= nack_d;
      tmo_q   <= tmo_d;
    end
  end

  assign clk_drive_low_o = (state_q == TX_INHIBIT) || (state_q == TX_SEIZE) ||
                           (state_q == TX_ABORT);
  assign dat_drive_low_o = (state_q == TX_SEIZE) || ((state_q == TX_XFER) && !frm_bit);
  assign busy_o          = (state_q != TX_IDLE);
  assign done_o          = done_q;
  assign nack_o          = nack_q;
  assign timeout_o       = tmo_q;

  // the data line never shows a falling edge the block acts on
  logic unused_ok;
  assign unused_ok = dat_fall & clk_lvl;

endmodule

// File: rtl/ps2_cmd_tx_chk.sv
module ps2_cmd_tx_chk
  import ps2tx_pkg::*;
#(
  parameter int INH_CYC = 100
) (
  input logic      clk,
  input logic      rst_n,
  input logic      start_i,
  input logic      abort_i,
  input logic      ps2_clk_i,
  input logic      clk_drive_low_o,
  input logic      dat_drive_low_o,
  input logic      busy_o,
  input logic      done_o,
  input logic      nack_o,
  input logic      timeout_o,
  input tx_state_e st
);

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_run <= 0;
    else if (clk_drive_low_o) low_run <= low_run + 1;
    else                      low_run <= 0;
  end

  AST_INHIBIT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_drive_low_o) |-> low_run >= INH_CYC) else $error("inhibit short"); // R2

  AST_RTS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_drive_low_o) && busy_o) |-> (dat_drive_low_o && $past(dat_drive_low_o)))
    else $error("request-to-send order"); // R3

  AST_CLK_HANDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !clk_drive_low_o && !abort_i) |=> !clk_drive_low_o)
    else $error("host toggled clock"); // R4

  AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_XFER && $past(st) == TX_XFER && dat_drive_low_o != $past(dat_drive_low_o))
    |-> !$past(ps2_clk_i, 3)) else $error("data moved with clock high"); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done too long"); // R6

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !clk_drive_low_o && !dat_drive_low_o)) else $error("done busy"); // R6

  AST_ERR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_o || timeout_o) |-> (!clk_drive_low_o && !dat_drive_low_o)) else $error("err lines"); // R7

  AST_IDLE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && abort_i && !start_i) |=> !busy_o) else $error("idle abort acted"); // R10

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, nack_o, timeout_o})) else $error("two outcomes"); // R11

endmodule

bind ps2_cmd_tx ps2_cmd_tx_chk #(.INH_CYC(INH_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
  .ps2_clk_i(ps2_clk_i), .clk_drive_low_o(clk_drive_low_o),
  .dat_drive_low_o(dat_drive_low_o), .busy_o(busy_o), .done_o(done_o),
  .nack_o(nack_o), .timeout_o(timeout_o), .st(state_q)
);

// File: tb/ps2_cmd_tx_test.sv
`timescale 1ns/1ps
module ps2_cmd_tx_test;

  localparam int CPU  = 1;
  localparam int IUS  = 100;
  localparam int TUS  = 2000;
  localparam int INH  = CPU * IUS;
  localparam int TMO  = CPU * TUS;
  localparam int HALF = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] cmd_i = 8'h00;
  logic       abort_i = 1'b0;
  logic       dev_clk_low = 1'b0;
  logic       dev_dat_low = 1'b0;
  logic       clk_drive_low_o, dat_drive_low_o, busy_o, done_o, nack_o, timeout_o;

  wire clk_line = !(clk_drive_low_o || dev_clk_low);
  wire dat_line = !(dat_drive_low_o || dev_dat_low);

  always #2.5 clk = ~clk;

  ps2_cmd_tx #(.CYC_PER_US(CPU), .INHIBIT_US(IUS), .TIMEOUT_US(TUS)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .abort_i(abort_i),
    .ps2_clk_i(clk_line), .ps2_dat_i(dat_line),
    .clk_drive_low_o(clk_drive_low_o), .dat_drive_low_o(dat_drive_low_o),
    .busy_o(busy_o), .done_o(done_o), .nack_o(nack_o), .timeout_o(timeout_o)
  );

  int total = 0;
  int bad   = 0;
  bit cmp_en = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phases 0 idle, 1 inhibit, 2 seize, 3 transfer, 4 abort
  int         ph, mcnt, mfalls;
  logic [9:0] mbits;
  logic       mcur;
  logic [3:0] ch, dh;
  logic       fev, ack_low, e_done, e_nack, e_tmo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; mcnt = 0; mfalls = 0; mbits = '1; mcur = 1'b1;
      ch = 4'hF; dh = 4'hF; e_done = 0; e_nack = 0; e_tmo = 0;
    end else begin
      ch = {ch[2:0], clk_line};
      dh = {dh[2:0], dat_line};
      fev = ch[3] & ~ch[2];          // fall acted on three edges after it appears
      ack_low = ~dh[2];
      e_done = 0; e_nack = 0; e_tmo = 0;
      case (ph)
        0: if (start_i) begin ph = 1; mcnt = INH; mbits = {1'b1, ~^cmd_i, cmd_i}; end
        1: if (abort_i) begin ph = 4; mcnt = INH; end
           else begin mcnt--; if (mcnt == 0) ph = 2; end
        2: if (abort_i) begin ph = 4; mcnt = INH; end
           else begin ph = 3; mcnt = TMO; mfalls = 0; mcur = 1'b0; end
        3: if (abort_i) begin ph = 4; mcnt = INH; end
           else if (fev) begin
             mfalls++;
             if (mfalls == 11) begin
               ph = 0;
               if (ack_low) e_done = 1; else e_nack = 1;
             end else mcur = mbits[mfalls-1];
           end else if (mfalls == 0) begin
             mcnt--;
             if (mcnt == 0) begin ph = 0; e_tmo = 1; end
           end
        default: begin mcnt--; if (mcnt == 0) ph = 0; end
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  int n_done = 0, n_nack = 0, n_tmo = 0;
  logic prev_clk_low = 0, prev_dat_low = 0;
  int   low_len = 0;

  always @(negedge clk) begin
    if (cmp_en) begin
      logic ec, ed, eb;
      ec = (ph == 1) || (ph == 2) || (ph == 4);
      ed = (ph == 2) || ((ph == 3) && !mcur);
      eb = (ph != 0);
      check(clk_drive_low_o == ec, "R2/R4 clock enable", clk_drive_low_o, ec);
      check(dat_drive_low_o == ed, "R5 data enable", dat_drive_low_o, ed);
      check(busy_o == eb, "R9 busy", busy_o, eb);
      check(done_o == e_done, "R6 done", done_o, e_done);
      check(nack_o == e_nack, "R7 nack", nack_o, e_nack);
      check(timeout_o == e_tmo, "R8 timeout", timeout_o, e_tmo);
      check((done_o + nack_o + timeout_o) <= 1, "R11 single outcome",
            done_o + nack_o + timeout_o, 1);
      if (prev_clk_low && !clk_drive_low_o && busy_o) begin
        check(prev_dat_low && dat_drive_low_o, "R3 data low before clock release",
              {prev_dat_low, dat_drive_low_o}, 2'b11);
        check(low_len == INH + 1, "R2 inhibit length", low_len, INH + 1);
      end
      if (done_o) n_done++;
      if (nack_o) n_nack++;
      if (timeout_o) n_tmo++;
    end
    low_len      = clk_drive_low_o ? low_len + 1 : 0;
    prev_clk_low = clk_drive_low_o;
    prev_dat_low = dat_drive_low_o;
  end

  // device model: waits for request-to-send, then clocks the frame in
  task automatic dev_run(input int pulses, input logic ackl, output logic [10:0] got);
    int w = 0;
    got = '0;
    while (!(clk_line && !dat_line && busy_o) && w < 20000) begin
      @(negedge clk); w++;
    end
    repeat (10) @(negedge clk);
    for (int p = 1; p <= pulses; p++) begin
      if (p == 11) dev_dat_low = ackl;
      repeat (HALF) @(negedge clk);
      dev_clk_low = 1'b1;
      repeat (HALF) @(negedge clk);
      got[p-1] = dat_line;
      dev_clk_low = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    dev_dat_low = 1'b0;
  endtask

  task automatic pulse_start(input logic [7:0] b);
    @(negedge clk);
    cmd_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int w = 0;
    while (busy_o && w < 20000) begin @(negedge clk); w++; end
    repeat (5) @(negedge clk);
  endtask

  task automatic send_and_check(input logic [7:0] b, input logic ackl);
    logic [10:0] got;
    int d0, n0;
    d0 = n_done; n0 = n_nack;
    pulse_start(b);
    dev_run(11, ackl, got);
    wait_idle();
    check(got[7:0] == b, "R5 data bits lsb first", got[7:0], b);
    check(got[8] == ~^b, "R5 odd parity", got[8], ~^b);
    check(got[9] == 1'b1, "R5 stop released", got[9], 1);
    if (ackl) check(n_done == d0 + 1, "R6 done counted", n_done - d0, 1);
    else      check(n_nack == n0 + 1, "R7 nack counted", n_nack - n0, 1);
  endtask

  initial begin
    logic [10:0] got;
    int d0, n0, t0;
    repeat (3) @(negedge clk);
    check({clk_drive_low_o, dat_drive_low_o, busy_o, done_o, nack_o, timeout_o} == 6'b0,
          "R1 outputs in reset", {clk_drive_low_o, dat_drive_low_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check({clk_drive_low_o, dat_drive_low_o, busy_o, done_o, nack_o, timeout_o} == 6'b0,
          "R1 outputs after reset", {clk_drive_low_o, dat_drive_low_o, busy_o}, 0);
    cmp_en = 1;

    send_and_check(8'hA5, 1'b1);
    send_and_check(8'h00, 1'b1);
    send_and_check(8'hFF, 1'b1);
    send_and_check(8'h3C, 1'b0);   // R7 missing acknowledge

    // R8 device stays silent
    t0 = n_tmo;
    pulse_start(8'h55);
    wait_idle();
    check(n_tmo == t0 + 1, "R8 timeout counted", n_tmo - t0, 1);

    // R9 abort after four device pulses
    d0 = n_done; n0 = n_nack; t0 = n_tmo;
    pulse_start(8'h81);
    dev_run(4, 1'b1, got);
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    check(clk_drive_low_o && !dat_drive_low_o, "R9 abort holds clock, frees data",
          {clk_drive_low_o, dat_drive_low_o}, 2'b10);
    wait_idle();
    check((n_done - d0) + (n_nack - n0) + (n_tmo - t0) == 0, "R9 no outcome on abort",
          (n_done - d0) + (n_nack - n0) + (n_tmo - t0), 0);

    // R9 abort during inhibit
    pulse_start(8'h42);
    repeat (30) @(negedge clk);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    wait_idle();
    check(!busy_o, "R9 idle after inhibit abort", busy_o, 0);

    // R10 abort while idle
    @(negedge clk); abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_o && !clk_drive_low_o, "R10 idle abort ignored", busy_o, 0);

    // R10 start while busy
    pulse_start(8'h12);
    repeat (40) @(negedge clk);
    cmd_i = 8'h99; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    dev_run(11, 1'b1, got);
    wait_idle();
    check(got[7:0] == 8'h12, "R10 busy start ignored", got[7:0], 8'h12);

    cmp_en = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule